// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line held high when idle. The line is taken through a two-stage synchronizer and looked at only when a sampling enable, supplied from outside at sixteen times the baud rate, is high. A high-to-low change of the line opens a frame. The receiver checks that the line is still low halfway through the start bit and then takes every later bit at its centre: the data bits, an optional parity bit and one or two stop bits.

The frame format is held in a small configuration register that is loaded with a strobe and comes out of reset as eight data bits, no parity and one stop bit. Each finished character, together with its parity and framing error flags, is written into a small first-word-fall-through queue. The host sees a flag while the queue holds anything, reads the head entry and removes it with a one-cycle read strobe. A character that completes while the queue is full is dropped, and a sticky overrun flag is raised.

Top module: `uart_os_rx`

## Requirements
- R1: The line passes through two synchronizing flops and is acted on only in cycles where `tick_16x` is high; with the enable held low, no amount of line activity produces a character.
- R2: A frame starts when, in the idle state, one enabled sample is high and the next is low. Eight enabled samples later the start bit is checked again. If the line is high at that point, the receiver returns to idle and no character is stored.
- R3: Data bits are taken every 16 enabled samples after the start-bit check, least significant bit first. A character of N bits is stored right-aligned in the 9-bit `rd_data`, and bits N..8 are zero.
- R4: `cfg_load` high copies the format inputs into the configuration register. `cfg_bits` gives the data bit count, with values below 5 read as 5 and values above 9 read as 9. `cfg_parity` is 2'b00 for none, 2'b01 for odd, 2'b10 for even and 2'b11 for none. `cfg_two_stop` is 1 for two stop bits. After reset the format is 8 data bits, no parity and 1 stop bit.
- R5: When parity is enabled, the parity bit follows the last data bit. For odd parity, the data bits and the parity bit together must hold an odd number of ones; for even parity, an even number. Otherwise `rd_perr` is 1 for that character. With parity off, `rd_perr` is 0.
- R6: `rd_ferr` is 1 for a character if any of its stop bits was sampled low. The character is still stored.
- R7: Characters leave the queue in arrival order. `data_avail` is high while the queue is not empty, and `rd_data`/`rd_perr`/`rd_ferr` show the oldest entry. `rd_en` removes that entry; `rd_en` on an empty queue changes nothing.
- R8: A character that completes while the queue holds DEPTH entries is discarded, and `overrun` goes to 1 and stays at 1 until reset.
- R9: After the centre of the last stop bit, the receiver is idle and accepts a start edge at once, so frames sent back to back with no idle gap are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | Sampling enable at 16x baud |
| rx_line | input | 1 | Serial input, idle high |
| cfg_load | input | 1 | Loads the format inputs |
| cfg_bits | input | 4 | Data bit count, 5 to 9 |
| cfg_parity | input | 2 | 00 none, 01 odd, 10 even, 11 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| rd_en | input | 1 | Removes the head entry |
| rd_data | output | 9 | Head character, right-aligned |
| rd_perr | output | 1 | Parity error of the head entry |
| rd_ferr | output | 1 | Framing error of the head entry |
| data_avail | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| overrun | output | 1 | Sticky: a character was dropped |

## Verification
The bench builds the receiver with its default 16 samples per bit and a queue depth of 4, and it drives the enable once every four clocks. With that depth, five frames sent without a read are enough to reach the overrun discard, and every queue slot and pointer wrap is also used in the ordinary tests. Four clocks per sample keep each 11-bit frame to about 700 cycles. This leaves room for every data width, every parity mode, both stop counts, start glitches and gapless frame trains in one short run.

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int OVS   = 16,
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_16x,
  input  logic       rx_line,
  input  logic       cfg_load,
  input  logic [3:0] cfg_bits,
  input  logic [1:0] cfg_parity,
  input  logic       cfg_two_stop,
  input  logic       rd_en,
  output logic [8:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       data_avail,
  output logic       fifo_full,
  output logic       overrun
);
  localparam int CW = $clog2(OVS);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] T_HALF = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] T_FULL = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [1:0]    sync;
  logic          rxs, rx_prev;
  logic [3:0]    n_bits;
  logic [1:0]    par_mode;
  logic          two_stop;
  st_t           state;
  logic [CW-1:0] tcnt;
  logic [3:0]    bcnt;
  logic [8:0]    shreg;
  logic          pbit, ferr_acc, done;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_line};
  end
  assign rxs = sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_bits   <= 4'd8;
      par_mode <= 2'b00;
      two_stop <= 1'b0;
    end else if (cfg_load) begin
      n_bits   <= (cfg_bits < 4'd5) ? 4'd5 : (cfg_bits > 4'd9) ? 4'd9 : cfg_bits;
      par_mode <= cfg_parity;
      two_stop <= cfg_two_stop;
    end
  end

  wire par_on = (par_mode == 2'b01) || (par_mode == 2'b10);
  wire at_mid = (tcnt == T_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      rx_prev  <= 1'b1;
      tcnt     <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      pbit     <= 1'b0;
      ferr_acc <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick_16x) begin
        case (state)
          S_IDLE: begin
            rx_prev <= rxs;
            if (rx_prev && !rxs) begin
              state <= S_START;
              tcnt  <= '0;
            end
          end
          S_START: begin
            if (tcnt == T_HALF) begin
              tcnt <= '0;
              if (rxs) begin
                state   <= S_IDLE;
                rx_prev <= 1'b1;
              end else begin
                state    <= S_DATA;
                bcnt     <= '0;
                shreg    <= '0;
                ferr_acc <= 1'b0;
                pbit     <= 1'b0;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          S_DATA: begin
            if (at_mid) begin
              tcnt  <= '0;
              shreg <= {rxs, shreg[8:1]};
              if (bcnt == n_bits - 4'd1) begin
                bcnt  <= '0;
                state <= par_on ? S_PAR : S_STOP;
              end else bcnt <= bcnt + 4'd1;
            end else tcnt <= tcnt + 1'b1;
          end
          S_PAR: begin
            if (at_mid) begin
              tcnt  <= '0;
              pbit  <= rxs;
              state <= S_STOP;
            end else tcnt <= tcnt + 1'b1;
          end
          S_STOP: begin
            if (at_mid) begin
              tcnt     <= '0;
              ferr_acc <= ferr_acc | ~rxs;
              if (two_stop && bcnt == 4'd0) bcnt <= 4'd1;
              else begin
                done    <= 1'b1;
                state   <= S_IDLE;
                rx_prev <= rxs;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  wire [8:0] chr  = shreg >> (4'd9 - n_bits);
  wire       ones = (^chr) ^ pbit;
  wire       perr = par_on && ((par_mode == 2'b01) ? !ones : ones);

  logic [10:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign fifo_full  = (cnt == (AW+1)'(DEPTH));
  assign data_avail = (cnt != '0);
  wire push = done && !fifo_full;
  wire pop  = rd_en && data_avail;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {ferr_acc, perr, chr};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      if (done && fifo_full) overrun <= 1'b1;
    end
  end

  assign {rd_ferr, rd_perr, rd_data} = mem[rp];

  AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> $past(tick_16x)); // R1
  AST_START_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && tick_16x && tcnt == T_HALF && rxs) |=> (state == S_IDLE && !done)); // R2
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH)); // R7
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !data_avail && !done) |=> !data_avail); // R7
  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fifo_full && !rd_en) |=> (fifo_full && overrun)); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8
endmodule

// File: tb/uart_os_rx_tb_top.sv
module uart_os_rx_tb_top;
  localparam int DEPTH = 4;
  localparam int TD    = 4;
  localparam int BITT  = 16 * TD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_16x = 1'b0;
  logic rx_line = 1'b1;
  logic cfg_load = 1'b0;
  logic [3:0] cfg_bits = 4'd8;
  logic [1:0] cfg_parity = 2'b00;
  logic cfg_two_stop = 1'b0;
  logic rd_en = 1'b0;
  logic [8:0] rd_data;
  logic rd_perr, rd_ferr, data_avail, fifo_full, overrun;

  always #10 clk = ~clk;

  uart_os_rx #(.OVS(16), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rx_line(rx_line),
    .cfg_load(cfg_load), .cfg_bits(cfg_bits), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .rd_en(rd_en), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .data_avail(data_avail),
    .fifo_full(fifo_full), .overrun(overrun));

  int errors = 0, checks = 0;
  int div = 0;
  bit tick_en = 1'b1;
  bit settled = 1'b0;
  bit ovr_exp = 1'b0;
  string cur_req = "R3";
  logic [10:0] q[$];

  int m_bits = 8, m_par = 0;
  bit m_two = 1'b0;

  always @(negedge clk) begin
    div <= (div == TD - 1) ? 0 : div + 1;
    tick_16x <= tick_en && (div == TD - 1);
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (settled && rst_n) begin
      check(data_avail == (q.size() != 0), "R7", "data_avail", int'(data_avail), int'(q.size() != 0));
      check(overrun == ovr_exp, "R8", "overrun", int'(overrun), int'(ovr_exp));
      check(fifo_full == (q.size() == DEPTH), "R8", "fifo_full", int'(fifo_full), int'(q.size() == DEPTH));
      if (q.size() != 0 && data_avail)
        check({rd_ferr, rd_perr, rd_data} == q[0], cur_req, "head entry",
              int'({rd_ferr, rd_perr, rd_data}), int'(q[0]));
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cfg(input int nb, input int pm, input bit two, input int eff_nb, input int eff_pm);
    @(negedge clk); #1;
    cfg_bits = 4'(nb); cfg_parity = 2'(pm); cfg_two_stop = two; cfg_load = 1'b1;
    @(posedge clk); #1 cfg_load = 1'b0;
    m_bits = eff_nb; m_par = eff_pm; m_two = two;
  endtask

  task automatic drive_bit(input bit b);
    @(negedge clk); #1 rx_line = b;
    hold(BITT - 1);
  endtask

  task automatic send(input int val, input bit bad_par, input bit bad_s1, input bit bad_s2, input bit gap);
    int data;
    bit p;
    logic [10:0] e;
    settled = 1'b0;
    data = val & ((1 << m_bits) - 1);
    drive_bit(1'b0);
    for (int i = 0; i < m_bits; i++) drive_bit(data[i]);
    if (m_par == 1 || m_par == 2) begin
      p = ($countones(data) % 2 == 0) ? (m_par == 1) : (m_par == 2);
      drive_bit(p ^ bad_par);
    end
    drive_bit(!bad_s1);
    if (m_two) drive_bit(!bad_s2);
    e = {bad_s1 | (m_two & bad_s2), bad_par & (m_par == 1 || m_par == 2), 9'(data)};
    if (q.size() == DEPTH) ovr_exp = 1'b1;
    else q.push_back(e);
    if (gap) begin
      @(negedge clk); #1 rx_line = 1'b1;
      hold(2 * BITT);
      settled = 1'b1;
    end
  endtask

  task automatic read_one;
    @(negedge clk); #1 rd_en = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0;
    if (q.size() != 0) void'(q.pop_front());
  endtask

  task automatic drain;
    while (q.size() != 0) read_one();
    hold(2);
  endtask

  initial begin
    int guard = 0;
    fork
      begin : wd
        while (guard < 200000) begin @(posedge clk); guard++; end
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<%0d", guard, 200000);
      end
      begin : main
        hold(5);
        @(negedge clk); #1 rst_n = 1'b1;
        hold(BITT);
        check(!data_avail && !overrun && !fifo_full, "R7", "reset state",
              int'({data_avail, overrun, fifo_full}), 0);
        settled = 1'b1;

        cur_req = "R4"; // default 8-n-1 after reset
        send(8'hA5, 0, 0, 0, 1); send(8'h3C, 0, 0, 0, 1); drain();

        cur_req = "R3";
        load_cfg(5, 0, 0, 5, 0);
        send(5'h13, 0, 0, 0, 1); send(5'h0E, 0, 0, 0, 1); drain();
        load_cfg(9, 0, 0, 9, 0);
        send(9'h1A7, 0, 0, 0, 1); drain();

        cur_req = "R5";
        load_cfg(7, 2, 0, 7, 2);
        send(7'h55, 0, 0, 0, 1); send(7'h54, 1, 0, 0, 1); drain();
        load_cfg(9, 1, 0, 9, 1);
        send(9'h0FF, 0, 0, 0, 1); send(9'h101, 1, 0, 0, 1); send(9'h000, 0, 0, 0, 1); drain();

        cur_req = "R4"; // clamping and parity code 11
        load_cfg(3, 3, 0, 5, 0);
        send(5'h1F, 0, 0, 0, 1); drain();
        load_cfg(15, 0, 0, 9, 0);
        send(9'h155, 0, 0, 0, 1); drain();

        cur_req = "R6";
        load_cfg(8, 0, 1, 8, 0);
        send(8'h81, 0, 0, 0, 1); send(8'h42, 0, 0, 1, 1); drain();
        load_cfg(8, 1, 0, 8, 1);
        send(8'h99, 0, 1, 0, 1); drain();

        cur_req = "R2";
        load_cfg(8, 0, 0, 8, 0);
        settled = 1'b0;
        @(negedge clk); #1 rx_line = 1'b0; hold(3 * TD);
        @(negedge clk); #1 rx_line = 1'b1; hold(3 * BITT);
        settled = 1'b1; hold(4);
        check(!data_avail, "R2", "glitch stored nothing", int'(data_avail), 0);
        send(8'h6E, 0, 0, 0, 1); drain();

        cur_req = "R1";
        settled = 1'b0; tick_en = 1'b0;
        @(negedge clk); #1 rx_line = 1'b0; hold(12 * BITT);
        @(negedge clk); #1 rx_line = 1'b1; hold(BITT);
        tick_en = 1'b1; hold(2 * BITT);
        settled = 1'b1; hold(4);
        check(!data_avail, "R1", "no character without enable", int'(data_avail), 0);

        cur_req = "R7";
        read_one(); hold(4);
        check(!data_avail, "R7", "read on empty ignored", int'(data_avail), 0);
        send(8'h11, 0, 0, 0, 1); send(8'h22, 0, 0, 0, 1); send(8'h33, 0, 0, 0, 1);
        read_one(); send(8'h44, 0, 0, 0, 1); send(8'h55, 0, 0, 0, 1);
        check(q.size() == 4, "R7", "model depth", q.size(), 4);
        drain();

        cur_req = "R9";
        load_cfg(6, 2, 0, 6, 2);
        send(6'h2A, 0, 0, 0, 0); send(6'h15, 0, 0, 0, 0); send(6'h3F, 1, 0, 0, 1); drain();

        cur_req = "R8";
        load_cfg(8, 0, 0, 8, 0);
        for (int i = 0; i < 5; i++) send(8'hC0 + i, 0, 0, 0, 1);
        check(overrun == 1'b1, "R8", "overrun raised", int'(overrun), 1);
        drain();
        hold(BITT);
        check(overrun == 1'b1, "R8", "overrun sticky", int'(overrun), 1);
        disable wd;
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule